// File: doc/BRIEF.md
# Profiling Match Array

This block is a small content-addressable array for a profiling engine. It keeps one key per slot, typically the program counter of an instruction under observation, along with a valid flag per slot. A requester issues one operation per cycle: store a key into a named slot, clear a slot, or search the array for a key. A search returns a hit flag and the slot that matched, always one cycle after the request. There is no backing store and no miss handling. A miss is only reported, and the requester decides what to do next.

To help the requester place a new key after a miss, the block always offers a replacement slot. While any slot is empty, it offers the lowest-numbered empty slot. Once every slot is occupied, it offers a pseudo-random slot taken from a free-running shift register. This spreads evictions so that a repeating program pattern cannot keep evicting the same entry. The key width and the slot count are parameters. Any data indexed by the returned slot is held outside this block.

Top module: `prof_match_array`

## Requirements
- R1: After reset every slot is empty, `rspValid` is low and `replSlot` is 0.
- R2: `opKind` encodes 2'b00 search, 2'b01 store, 2'b10 clear and 2'b11 no operation. When `opValid` is low, or the kind is 2'b11, the array state does not change and no response is produced.
- R3: A search request in cycle t raises `rspValid` in cycle t+1 only. `rspValid` is never raised for a store, a clear or a no operation.
- R4: A store writes `opKey` into slot `opSlot` and marks the slot valid. A search issued in any later cycle for that key hits with that slot.
- R5: A store into an occupied slot replaces its key, and the old key no longer matches in that slot.
- R6: A clear marks slot `opSlot` empty. An empty slot never matches, even when its stored key equals the search key.
- R7: A search with no matching valid slot returns `rspHit`=0 and `rspSlot`=0.
- R8: When several valid slots hold the search key, the lowest-numbered one is reported.
- R9: While at least one slot is empty, `replSlot` is the lowest-numbered empty slot, and it reflects stores and clears from the cycle after they are issued.
- R10: While every slot is valid, `replSlot` is a pseudo-random value below ENTRIES that changes over successive cycles. It is taken from a 16-bit shift register that advances every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation request this cycle |
| opKind | input | 2 | Operation kind (see R2) |
| opSlot | input | SLOT_W | Target slot for store and clear |
| opKey | input | KEY_W | Key to store or search for |
| rspValid | output | 1 | Search result valid |
| rspHit | output | 1 | A valid slot matched |
| rspSlot | output | SLOT_W | Lowest matching slot |
| replSlot | output | SLOT_W | Suggested slot for a new key |

## Verification
The assertions assume that `opSlot` is always below ENTRIES for stores and clears. They also assume that at most one operation is presented per cycle, which the single request port enforces. The bench drives only in-range slots. It changes inputs on the falling edge, so each operation is sampled by exactly one rising edge. Duplicate keys and keys left in cleared slots are created on purpose. This lets the priority and empty-slot rules be exercised inside these assumptions.

// File: rtl/prof_match_pkg.sv
`timescale 1ns/1ps
package prof_match_pkg;
  typedef enum logic [1:0] {
    OP_SEARCH = 2'b00,
    OP_STORE  = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_NONE   = 2'b11
  } opKind_e;

  typedef struct packed {
    logic wrEn;
    logic invEn;
    logic lkEn;
  } arrStrobe_t;
endpackage

// File: rtl/prof_match_ctrl.sv
`timescale 1ns/1ps
module prof_match_ctrl
  import prof_match_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int LFSR_W  = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  input  logic [1:0]         opKind,
  input  logic [ENTRIES-1:0] validVec,
  output arrStrobe_t         strobe,
  output logic [SLOT_W-1:0]  replSlot
);
  logic [LFSR_W-1:0] lfsrQ;
  logic [SLOT_W-1:0] randSlot;
  logic [SLOT_W-1:0] freeSlot;
  logic              anyFree;

  always_comb begin
    strobe = '0;
    if (opValid) begin
      unique case (opKind_e'(opKind))
        OP_SEARCH: strobe.lkEn  = 1'b1;
        OP_STORE:  strobe.wrEn  = 1'b1;
        OP_CLEAR:  strobe.invEn = 1'b1;
        default:   strobe = '0;
      endcase
    end
  end

  // Galois shift register, never zero once seeded
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsrQ <= LFSR_W'(1);
    else if (lfsrQ[0]) lfsrQ <= (lfsrQ >> 1) ^ LFSR_TAPS;
    else lfsrQ <= lfsrQ >> 1;
  end

  assign randSlot = SLOT_W'(lfsrQ % LFSR_W'(ENTRIES));

  always_comb begin
    anyFree  = 1'b0;
    freeSlot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        anyFree  = 1'b1;
        freeSlot = SLOT_W'(i);
      end
    end
  end

  assign replSlot = anyFree ? freeSlot : randSlot;

  p_one_op_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrEn, strobe.invEn, strobe.lkEn}));

  p_repl_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    (validVec != {ENTRIES{1'b1}}) |-> !validVec[replSlot]);

  p_repl_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    (validVec == {ENTRIES{1'b1}}) |-> (int'(replSlot) < ENTRIES));

  p_lfsr_alive_r10: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);
endmodule

// File: rtl/prof_match_datapath.sv
`timescale 1ns/1ps
module prof_match_datapath
  import prof_match_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 32,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  arrStrobe_t         strobe,
  input  logic [SLOT_W-1:0]  slot,
  input  logic [KEY_W-1:0]   key,
  output logic [ENTRIES-1:0] validVec,
  output logic               rspValid,
  output logic               rspHit,
  output logic [SLOT_W-1:0]  rspSlot
);
  logic [KEY_W-1:0]   keyMem [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] matchVec;
  logic               anyMatch;
  logic [SLOT_W-1:0]  firstMatch;

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    assign matchVec[g] = validQ[g] && (keyMem[g] == key);

    always_ff @(posedge clk) begin
      if (strobe.wrEn && (slot == SLOT_W'(g))) keyMem[g] <= key;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) validQ[g] <= 1'b0;
      else if (slot == SLOT_W'(g)) begin
        if (strobe.wrEn) validQ[g] <= 1'b1;
        else if (strobe.invEn) validQ[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    anyMatch   = 1'b0;
    firstMatch = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyMatch   = 1'b1;
        firstMatch = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspSlot  <= '0;
    end else begin
      rspValid <= strobe.lkEn;
      if (strobe.lkEn) begin
        rspHit  <= anyMatch;
        rspSlot <= firstMatch;
      end
    end
  end

  assign validVec = validQ;

  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lkEn |=> rspValid);

  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lkEn |=> !rspValid);

  p_hit_key_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> (validQ[rspSlot] && keyMem[rspSlot] == $past(key)));

  p_store_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> validQ[$past(slot)]);

  p_clear_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.invEn |=> !validQ[$past(slot)]);

  p_miss_slot_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspSlot == '0));
endmodule

// File: rtl/prof_match_array.sv
`timescale 1ns/1ps
module prof_match_array
  import prof_match_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 32,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opKind,
  input  logic [SLOT_W-1:0] opSlot,
  input  logic [KEY_W-1:0]  opKey,
  output logic              rspValid,
  output logic              rspHit,
  output logic [SLOT_W-1:0] rspSlot,
  output logic [SLOT_W-1:0] replSlot
);
  arrStrobe_t         strobe;
  logic [ENTRIES-1:0] validVec;

  prof_match_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .validVec(validVec), .strobe(strobe), .replSlot(replSlot)
  );

  prof_match_datapath #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slot(opSlot), .key(opKey),
    .validVec(validVec), .rspValid(rspValid), .rspHit(rspHit), .rspSlot(rspSlot)
  );
endmodule

// File: tb/sim_prof_match_array.sv
`timescale 1ns/1ps
module sim_prof_match_array;
  localparam int N = 16;
  localparam int KW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [1:0] opKind = 2'b11;
  logic [3:0] opSlot = '0;
  logic [KW-1:0] opKey = '0;
  logic rspValid, rspHit;
  logic [3:0] rspSlot, replSlot;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  // reference model
  logic [KW-1:0] refKey [N];
  bit refValid [N];

  always #2 clk = ~clk;

  prof_match_array #(.ENTRIES(N), .KEY_W(KW)) u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .opSlot(opSlot), .opKey(opKey), .rspValid(rspValid), .rspHit(rspHit),
    .rspSlot(rspSlot), .replSlot(replSlot)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int modelRepl();
    for (int i = 0; i < N; i++) if (!refValid[i]) return i;
    return -1;
  endfunction

  // one operation: drive at negedge, check at the following negedge
  task automatic doOp(input bit v, input logic [1:0] k, input int s,
                      input logic [KW-1:0] key, input string req);
    bit expV, expH;
    int expS, r;
    @(negedge clk);
    opValid = v; opKind = k; opSlot = 4'(s); opKey = key;
    expV = v && (k == 2'b00);
    expH = 0; expS = 0;
    if (expV) begin
      for (int i = N - 1; i >= 0; i--)
        if (refValid[i] && refKey[i] == key) begin expH = 1; expS = i; end
    end
    @(posedge clk);
    if (v && k == 2'b01) begin refKey[s] = key; refValid[s] = 1; end
    if (v && k == 2'b10) refValid[s] = 0;
    @(negedge clk);
    opValid = 0; opKind = 2'b11;
    chk(rspValid == expV, {req, " rspValid"}, rspValid, expV);
    if (expV) begin
      chk(rspHit == expH, {req, " rspHit"}, rspHit, expH);
      chk(int'(rspSlot) == expS, {req, " rspSlot"}, rspSlot, expS);
    end
    r = modelRepl();
    if (r >= 0) chk(int'(replSlot) == r, "R9 replSlot", replSlot, r);
    else chk(int'(replSlot) < N, "R10 replSlot range", replSlot, N - 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int distinct;
    bit seen [N];
    for (int i = 0; i < N; i++) begin refValid[i] = 0; refKey[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rspValid == 0, "R1 rspValid", rspValid, 0);
    chk(replSlot == 0, "R1 replSlot", replSlot, 0);
    rstN = 1;
    doOp(1, 2'b00, 0, 32'h0, "R1 search empty");
    doOp(1, 2'b00, 0, 32'h1000, "R7 miss empty");

    // R4 store then search
    doOp(1, 2'b01, 0, 32'h1000, "R3 store no rsp");
    doOp(1, 2'b00, 0, 32'h1000, "R4 hit slot0");
    doOp(1, 2'b01, 5, 32'h2040, "R4 store slot5");
    doOp(1, 2'b00, 0, 32'h2040, "R4 hit slot5");
    // R9 lowest free after gap
    doOp(1, 2'b01, 1, 32'h3000, "R9 fill slot1");
    // R2 no-op and idle do nothing
    doOp(1, 2'b11, 2, 32'h3000, "R2 noop");
    doOp(0, 2'b01, 2, 32'h3000, "R2 opValid low");
    doOp(1, 2'b00, 0, 32'hDEAD, "R7 miss");
    // R8 duplicates: key 0x2040 into slot 3 too
    doOp(1, 2'b01, 3, 32'h2040, "R8 dup store");
    doOp(1, 2'b00, 0, 32'h2040, "R8 lowest dup");
    // R5 overwrite slot 3 with new key, old stays only in 5
    doOp(1, 2'b01, 3, 32'h4444, "R5 overwrite");
    doOp(1, 2'b00, 0, 32'h4444, "R5 new key");
    doOp(1, 2'b01, 5, 32'h5555, "R5 overwrite 5");
    doOp(1, 2'b00, 0, 32'h2040, "R5 old key gone");
    // R6 clear then search stale key
    doOp(1, 2'b10, 0, 32'h0, "R6 clear slot0");
    doOp(1, 2'b00, 0, 32'h1000, "R6 stale miss");
    doOp(1, 2'b10, 3, 32'h0, "R6 clear slot3");
    doOp(1, 2'b00, 0, 32'h4444, "R6 stale miss3");
    // back-to-back searches
    doOp(1, 2'b00, 0, 32'h3000, "R3 b2b a");
    doOp(1, 2'b00, 0, 32'h5555, "R3 b2b b");

    // fill all slots
    for (int i = 0; i < N; i++) doOp(1, 2'b01, i, 32'hA000 + 32'(i), "R9 fill");
    for (int i = 0; i < N; i += 5) doOp(1, 2'b00, 0, 32'hA000 + 32'(i), "R4 full hit");
    doOp(1, 2'b00, 0, 32'hBEEF, "R7 full miss");

    // R10 random variety while full
    for (int i = 0; i < N; i++) seen[i] = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      chk(int'(replSlot) < N, "R10 range", replSlot, N - 1);
      seen[replSlot] = 1;
    end
    distinct = 0;
    for (int i = 0; i < N; i++) if (seen[i]) distinct++;
    chk(distinct >= 4, "R10 variety", distinct, 4);

    // free one slot: R9 returns it
    doOp(1, 2'b10, 9, 32'h0, "R9 clear 9");
    doOp(1, 2'b10, 4, 32'h0, "R9 clear 4");
    doOp(1, 2'b01, 4, 32'h7, "R9 refill 4");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule